// File: doc/BRIEF.md
# Zero-Turnaround Pipelined Synchronous SRAM

This block is a single-port synchronous static memory whose read and write data phases both sit a fixed two clock edges behind the command. The host can therefore alternate reads and writes on every cycle and never waits for the bus to turn around. The default size is 256 words of two 9-bit byte lanes. Every input except the output enable is sampled on the rising clock edge. The shared data bus is tri-stated whenever the memory has nothing to put on it.

A command cycle either loads a new address or advances an on-chip 4-beat burst counter. A load starts a read or a write only when all three chip selects are asserted. An advance steps through the aligned 4-word block in linear or interleaved order and keeps the direction of the load that opened the burst. An active-low clock enable freezes the whole pipeline, and active-low lane strobes choose which byte lanes a write beat updates.

Top module: `zbt_ram`

## Requirements
- R1: A command is sampled on enabled edge k. For a write, `dq` is captured on enabled edge k+2. For a read, the word is on `dq` from just after enabled edge k+1 up to edge k+2.
- R2: Commands of either direction are accepted on consecutive enabled cycles with no idle slot. A read issued on the cycle right after a write to the same address returns the newly written lanes.
- R3: While `clk_en_n` is 1, every input except `out_en_n` is ignored, no memory word changes, and the bus keeps showing the data phase in progress.
- R4: On a load cycle (`adv` = 0), an operation starts only if `sel_a_n` = 0, `sel_b` = 1 and `sel_c_n` = 0. Otherwise nothing is read or written, and operations already in the pipeline still complete.
- R5: `dq` is high impedance during the data phase of a write or of a cycle that started no operation.
- R6: An advance cycle (`adv` = 1) after a selected load issues the next beat in the direction of that load. `rd_wr_n` is ignored on advance cycles. Beats repeat every four advances.
- R7: With `lin_order` = 1 sampled at the load, beat n uses address low bits (base + n) mod 4. The bits above bit 1 always stay those of the loaded address.
- R8: With `lin_order` = 0 sampled at the load, beat n uses address low bits base XOR n.
- R9: While `out_en_n` = 1, `dq` is high impedance at once, whatever the pipeline holds.
- R10: `lane_wr_n[i]` = 0 on a write beat's command cycle enables lane i, which is bits [9i+8:9i] of `dq` at the default lane width. Lanes whose strobe is 1 keep their old contents.
- R11: An advance cycle with no burst open, after reset or after a deselected load, starts no operation and leaves the bus at high impedance.
- R12: After synchronous reset (`rst` = 1), the pipeline holds no operation, no burst is open, and `dq` is high impedance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| clk_en_n | input | 1 | Active-low clock enable; 1 freezes the block |
| sel_a_n | input | 1 | Chip select, active low |
| sel_b | input | 1 | Chip select, active high |
| sel_c_n | input | 1 | Chip select, active low |
| adv | input | 1 | 1 = advance burst, 0 = load new address |
| rd_wr_n | input | 1 | 1 = read, 0 = write (used on loads only) |
| lin_order | input | 1 | 1 = linear burst order, 0 = interleaved |
| lane_wr_n | input | LANES | Active-low per-lane write strobes |
| addr | input | AW | Word address |
| out_en_n | input | 1 | Asynchronous active-low output enable |
| dq | inout | LANES*LANE_W | Bidirectional data bus |

## Verification
The bench builds the memory with 6 address bits, which gives 64 words, and keeps two 9-bit lanes. At that size it can write and read back every word, and it can run a burst from each of the four start offsets in both orders while it tracks the whole array in its own model. The small array also puts same-address write-then-read forwarding, single-lane writes, stalls placed in the middle of data phases, and each chip select dropped on its own within a short run.

// File: rtl/zbt_pkg.sv
package zbt_pkg;

  typedef enum logic {
    ORD_XOR = 1'b0,
    ORD_SEQ = 1'b1
  } burst_ord_e;

  // low two address bits of burst beat n
  function automatic logic [1:0] beat_low(input logic [1:0] base,
                                          input logic [1:0] n,
                                          input burst_ord_e ord);
    return (ord == ORD_SEQ) ? base + n : base ^ n;
  endfunction

endpackage

// File: rtl/zbt_cmd_ctl.sv
module zbt_cmd_ctl
  import zbt_pkg::*;
#(
  parameter int AW    = 8,
  parameter int LANES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step_en,
  input  logic             adv,
  input  logic             rd_wr_n,
  input  logic             sel_a_n,
  input  logic             sel_b,
  input  logic             sel_c_n,
  input  logic             lin_order,
  input  logic [LANES-1:0] lane_wr_n,
  input  logic [AW-1:0]    addr,
  output logic             c_vld,
  output logic             c_rd,
  output logic [AW-1:0]    c_addr,
  output logic [LANES-1:0] c_wen
);

  logic          selected;
  logic          burst_on;
  logic          dir_q;
  logic [AW-1:0] base_q;
  logic [1:0]    cnt_q;
  logic [1:0]    cnt_nx;
  burst_ord_e    ord_q;

  assign selected = !sel_a_n && sel_b && !sel_c_n;
  assign cnt_nx   = cnt_q + 2'd1;

  always_ff @(posedge clk) begin
    if (rst) begin
      c_vld    <= 1'b0;
      c_rd     <= 1'b0;
      c_addr   <= '0;
      c_wen    <= '0;
      burst_on <= 1'b0;
      dir_q    <= 1'b0;
      base_q   <= '0;
      cnt_q    <= '0;
      ord_q    <= ORD_XOR;
    end else if (step_en) begin
      c_wen <= ~lane_wr_n;
      if (!adv) begin
        if (selected) begin
          c_vld    <= 1'b1;
          c_rd     <= rd_wr_n;
          c_addr   <= addr;
          burst_on <= 1'b1;
          dir_q    <= rd_wr_n;
          base_q   <= addr;
          cnt_q    <= 2'd0;
          ord_q    <= burst_ord_e'(lin_order);
        end else begin
          c_vld    <= 1'b0;
          burst_on <= 1'b0;
        end
      end else if (burst_on) begin
        c_vld  <= 1'b1;
        c_rd   <= dir_q;
        cnt_q  <= cnt_nx;
        c_addr <= {base_q[AW-1:2], beat_low(base_q[1:0], cnt_nx, ord_q)};
      end else begin
        c_vld <= 1'b0;
      end
    end
  end

  p_desel_r4: assert property (@(posedge clk) disable iff (rst)
    (step_en && !adv && !selected) |=> !c_vld);

  p_dir_r6: assert property (@(posedge clk) disable iff (rst)
    (step_en && adv && burst_on) |=> (c_vld && c_rd == $past(dir_q)));

  p_upper_r7: assert property (@(posedge clk) disable iff (rst)
    (step_en && adv && burst_on) |=> (c_addr[AW-1:2] == $past(base_q[AW-1:2])));

  p_xor_r8: assert property (@(posedge clk) disable iff (rst)
    (step_en && adv && burst_on && ord_q == ORD_XOR)
      |=> ((c_addr[1:0] ^ $past(base_q[1:0])) == $past(cnt_q) + 2'd1));

  p_idle_adv_r11: assert property (@(posedge clk) disable iff (rst)
    (step_en && adv && !burst_on) |=> !c_vld);

  p_reset_r12: assert property (@(posedge clk)
    rst |=> (!c_vld && !burst_on));

endmodule

// File: rtl/zbt_store.sv
module zbt_store #(
  parameter int AW     = 8,
  parameter int LANES  = 2,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    en,
  input  logic                    we,
  input  logic [AW-1:0]           waddr,
  input  logic [LANES-1:0]        wlane,
  input  logic [LANES*LANE_W-1:0] wdata,
  input  logic                    re,
  input  logic [AW-1:0]           raddr,
  output logic [LANES*LANE_W-1:0] rdata
);

  localparam int DEPTH = 1 << AW;

  logic same_word;
  assign same_word = (waddr == raddr);

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];
    logic              lane_we;

    assign lane_we = we && wlane[i];

    always_ff @(posedge clk) begin
      if (en) begin
        if (lane_we)
          mem[waddr] <= wdata[i*LANE_W +: LANE_W];
        if (re)
          rdata[i*LANE_W +: LANE_W] <= (lane_we && same_word)
                                       ? wdata[i*LANE_W +: LANE_W]
                                       : mem[raddr];
      end
    end
  end

endmodule

// File: rtl/zbt_ram.sv
module zbt_ram #(
  parameter int AW     = 8,
  parameter int LANES  = 2,
  parameter int LANE_W = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clk_en_n,
  input  logic             sel_a_n,
  input  logic             sel_b,
  input  logic             sel_c_n,
  input  logic             adv,
  input  logic             rd_wr_n,
  input  logic             lin_order,
  input  logic [LANES-1:0] lane_wr_n,
  input  logic [AW-1:0]    addr,
  input  logic             out_en_n,
  inout  wire  [LANES*LANE_W-1:0] dq
);

  localparam int DW = LANES * LANE_W;

  logic             step_en;
  logic             c_vld, c_rd;
  logic [AW-1:0]    c_addr;
  logic [LANES-1:0] c_wen;

  logic             s2_vld, s2_rd;
  logic [AW-1:0]    s2_addr;
  logic [LANES-1:0] s2_wen;
  logic             drive_q;
  logic [DW-1:0]    rdata;

  assign step_en = !clk_en_n;

  zbt_cmd_ctl #(.AW(AW), .LANES(LANES)) u_ctl (
    .clk       (clk),
    .rst       (rst),
    .step_en   (step_en),
    .adv       (adv),
    .rd_wr_n   (rd_wr_n),
    .sel_a_n   (sel_a_n),
    .sel_b     (sel_b),
    .sel_c_n   (sel_c_n),
    .lin_order (lin_order),
    .lane_wr_n (lane_wr_n),
    .addr      (addr),
    .c_vld     (c_vld),
    .c_rd      (c_rd),
    .c_addr    (c_addr),
    .c_wen     (c_wen)
  );

  // second pipeline stage: write data phase and read drive flag
  always_ff @(posedge clk) begin
    if (rst) begin
      s2_vld  <= 1'b0;
      s2_rd   <= 1'b0;
      s2_addr <= '0;
      s2_wen  <= '0;
      drive_q <= 1'b0;
    end else if (step_en) begin
      s2_vld  <= c_vld;
      s2_rd   <= c_rd;
      s2_addr <= c_addr;
      s2_wen  <= c_wen;
      drive_q <= c_vld && c_rd;
    end
  end

  zbt_store #(.AW(AW), .LANES(LANES), .LANE_W(LANE_W)) u_store (
    .clk   (clk),
    .en    (step_en && !rst),
    .we    (s2_vld && !s2_rd),
    .waddr (s2_addr),
    .wlane (s2_wen),
    .wdata (dq),
    .re    (c_vld && c_rd),
    .raddr (c_addr),
    .rdata (rdata)
  );

  assign dq = (!out_en_n && drive_q) ? rdata : {DW{1'bz}};

  p_stall_hold_r3: assert property (@(posedge clk) disable iff (rst)
    clk_en_n |=> ($stable(s2_vld) && $stable(s2_addr) && $stable(drive_q)));

  p_write_quiet_r5: assert property (@(posedge clk) disable iff (rst)
    (s2_vld && !s2_rd) |-> !drive_q);

  p_read_drives_r1: assert property (@(posedge clk) disable iff (rst)
    (s2_vld && s2_rd) |-> drive_q);

  p_reset_r12: assert property (@(posedge clk)
    rst |=> (!drive_q && !s2_vld));

endmodule

// File: tb/sim_zbt_ram.sv
`timescale 1ns/1ps
module sim_zbt_ram;

  localparam int AW = 6, LANES = 2, LANE_W = 9;
  localparam int DW = LANES * LANE_W;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic clk_en_n = 1'b0, sel_a_n = 1'b1, sel_b = 1'b0, sel_c_n = 1'b1;
  logic adv = 1'b0, rd_wr_n = 1'b1, lin_order = 1'b0, out_en_n = 1'b1;
  logic [LANES-1:0] lane_wr_n = '1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] tb_dq = '0;
  logic tb_drv = 1'b0;
  wire  [DW-1:0] dq;

  assign dq = tb_drv ? tb_dq : {DW{1'bz}};

  always #2.5 clk = ~clk;

  zbt_ram #(.AW(AW), .LANES(LANES), .LANE_W(LANE_W)) u0 (
    .clk(clk), .rst(rst), .clk_en_n(clk_en_n), .sel_a_n(sel_a_n), .sel_b(sel_b),
    .sel_c_n(sel_c_n), .adv(adv), .rd_wr_n(rd_wr_n), .lin_order(lin_order),
    .lane_wr_n(lane_wr_n), .addr(addr), .out_en_n(out_en_n), .dq(dq));

  typedef struct packed {
    logic vld; logic rd; logic [AW-1:0] a; logic [LANES-1:0] ln; logic [DW-1:0] d;
  } ph_t;

  ph_t p1 = '0, p2 = '0;
  string t1 = "R12", t2 = "R12";
  logic b_on = 1'b0, b_rd = 1'b0, b_lin = 1'b0;
  logic [AW-1:0] b_base = '0;
  logic [1:0] b_cnt = '0;
  logic [DW-1:0] mdl [DEPTH];
  int seq = 0, n_chk = 0, n_bad = 0;
  bit done = 0;

  task automatic chk(input logic [DW-1:0] got, input logic [DW-1:0] exp, input string tag);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: dq=%h expected %h", tag, got, exp);
    end
  endtask

  // sel bit0=a asserted, bit1=b asserted, bit2=c asserted; lnw active-high lanes
  task automatic step(input logic en, input logic ad, input logic rw, input logic [2:0] sel,
                      input logic [AW-1:0] a, input logic [LANES-1:0] lnw,
                      input logic lin, input logic oe, input string tag);
    ph_t nw;
    logic [1:0] lo;
    @(negedge clk);
    out_en_n = !oe;
    if (p2.vld && !p2.rd) begin tb_dq = p2.d; tb_drv = 1'b1; end
    else tb_drv = 1'b0;
    #1;
    if (p2.vld && !p2.rd) begin
      if (en)
        for (int i = 0; i < LANES; i++)
          if (p2.ln[i]) mdl[p2.a][i*LANE_W +: LANE_W] = p2.d[i*LANE_W +: LANE_W];
    end else if (!oe) chk(dq, {DW{1'bz}}, "R9");
    else if (p2.vld) chk(dq, mdl[p2.a], t2);
    else chk(dq, {DW{1'bz}}, t2);
    clk_en_n = !en; adv = ad; rd_wr_n = rw;
    sel_a_n = !sel[0]; sel_b = sel[1]; sel_c_n = !sel[2];
    addr = a; lane_wr_n = ~lnw; lin_order = lin;
    if (en) begin
      nw = '0;
      if (!ad) begin
        if (&sel) begin
          nw.vld = 1'b1; nw.rd = rw; nw.a = a;
          b_on = 1'b1; b_rd = rw; b_base = a; b_cnt = 2'd0; b_lin = lin;
        end else b_on = 1'b0;
      end else if (b_on) begin
        b_cnt = b_cnt + 2'd1;
        lo = b_lin ? b_base[1:0] + b_cnt : b_base[1:0] ^ b_cnt;
        nw.vld = 1'b1; nw.rd = b_rd; nw.a = {b_base[AW-1:2], lo};
      end
      nw.ln = lnw;
      seq++;
      nw.d = DW'((seq * 1237) ^ (int'(nw.a) << 9) ^ 32'h155);
      p2 = p1; t2 = t1; p1 = nw; t1 = tag;
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [LANES-1:0] ln, input string tag);
    step(1, 0, 0, 3'b111, a, ln, 1, 1, tag);
  endtask
  task automatic rd(input logic [AW-1:0] a, input string tag);
    step(1, 0, 1, 3'b111, a, '0, 1, 1, tag);
  endtask
  task automatic idle(input string tag);
    step(1, 0, 1, 3'b000, '0, '0, 0, 1, tag);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not finish, got hang expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    // R12: empty pipeline after reset, bus released
    repeat (3) idle("R12");
    // R1: sweep every word
    for (int a = 0; a < DEPTH; a++) wr(AW'(a), 2'b11, "R1");
    for (int a = 0; a < DEPTH; a++) rd(AW'(a), "R1");
    idle("R5"); idle("R5");
    // R2: write then read the same word on the next cycle, mixed directions
    for (int a = 0; a < DEPTH; a += 3) begin
      wr(AW'(a), 2'b11, "R2"); rd(AW'(a), "R2"); rd(AW'(a + 1), "R2");
    end
    // R10: single-lane writes
    for (int a = 0; a < 16; a++) begin
      wr(AW'(a), 2'((a % 3) + 1), "R10"); rd(AW'(a), "R10");
    end
    // R3: stalls inside data phases with junk commands
    for (int a = 0; a < 12; a++) begin
      wr(AW'(a), 2'b11, "R3");
      step(0, 0, 0, 3'b111, AW'(a + 32), 2'b11, 0, 1, "R3");
      rd(AW'(a), "R3");
      step(0, 1, 0, 3'b111, AW'(a + 40), 2'b11, 0, 1, "R3");
    end
    for (int a = 32; a < 52; a++) rd(AW'(a), "R3");
    // R4: each select dropped alone, with a read pending
    for (int k = 0; k < 3; k++) begin
      rd(AW'(7), "R4");
      step(1, 0, 0, 3'b111 & ~(3'b001 << k), AW'(5 + k), 2'b11, 0, 1, "R4");
      rd(AW'(5 + k), "R4");
    end
    // R7 / R8 / R6: bursts from each offset, rw flipped on advance cycles
    for (int l = 0; l < 2; l++)
      for (int off = 0; off < 4; off++) begin
        step(1, 0, 0, 3'b111, AW'(16 + 4 * l + off), 2'b11, l[0], 1, l ? "R7" : "R8");
        for (int b = 0; b < 3; b++)
          step(1, 1, 1, 3'b000, '0, 2'b11, ~l[0], 1, l ? "R7" : "R8");
        step(1, 0, 1, 3'b111, AW'(16 + 4 * l + off), 2'b00, l[0], 1, "R6");
        for (int b = 0; b < 6; b++)
          step(1, 1, 0, 3'b000, '0, 2'b11, ~l[0], 1, "R6");
      end
    // R11: advances with no open burst
    idle("R11");
    for (int b = 0; b < 3; b++) step(1, 1, 0, 3'b111, AW'(20 + b), 2'b11, 1, 1, "R11");
    for (int a = 16; a < 24; a++) rd(AW'(a), "R11");
    // R9: output enable forced off during read phases
    for (int a = 0; a < 4; a++) begin
      rd(AW'(a), "R9");
      step(1, 0, 1, 3'b000, '0, '0, 0, 1, "R9");
      step(1, 0, 1, 3'b000, '0, '0, 0, 0, "R9");
    end
    idle("R5"); idle("R5"); idle("R5");
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule